// File: doc/BRIEF.md
# Lamp Strike and Lamp-Out Timeout Counter

This block watches each lamp channel of a fluorescent-lamp driver and measures, in lamp-frequency cycles, how long a lamp stays dark. After a strike attempt begins, a channel that never shows a lit lamp within the selected window raises a strike-timeout event. A channel whose lamp has lit at least once since the attempt began, then goes dark and stays dark for the same window, raises a lamp-out event. Each event is a one-clock pulse meant to set a sticky bit in a status register elsewhere.

A single 2-bit select, shared by all channels, picks the window length as a multiple of a base cycle count. The lamp-cycle tick is shared; the strike-attempt start and the lamp-lit indication are per channel. A lit lamp or a new strike attempt clears a channel's count. Once an event fires, the channel holds until it is cleared.

Top module: `lamp_timeout`

## Requirements
- R1: During and right after reset, both event outputs of every channel are 0 and every channel is idle.
- R2: The window is BASE_CYC ticks for select code 00, 2*BASE_CYC for code 01 and 3*BASE_CYC for code 10 (default BASE_CYC is 32768).
- R3: Select code 11 gives the longest window, 3*BASE_CYC ticks.
- R4: After a strike attempt with no lit indication since, the strike-timeout output pulses in the clock after the tick that brings the dark count to the window; the lamp-out output stays 0.
- R5: If the lamp was lit at least once since the last strike attempt, reaching the window raises the lamp-out output instead, also for one clock.
- R6: Any clock with the lit indication high resets that channel's dark count to zero and clears a held event.
- R7: A strike-attempt pulse resets the count, clears a held event and returns the channel to strike mode, even if it was watching for lamp-out.
- R8: Each event is a single-clock pulse; after it the channel holds and raises no further event until R6 or R7 clears it.
- R9: The count advances only on clocks where the tick input is high.
- R10: If the select is changed to a window at or below the count already reached, the event fires on the next tick.
- R11: Channels count independently under one shared select; events on one channel never depend on another channel's start or lit inputs.
- R12: A channel that has not seen a strike attempt since reset counts nothing and raises no event, whatever its lit and tick inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock pulse per lamp-frequency cycle |
| tsel_i | input | 2 | Shared timeout select code |
| start_i | input | NUM_CH | Per-channel strike-attempt start pulse |
| lit_i | input | NUM_CH | Per-channel lamp-lit indication |
| strike_to_o | output | NUM_CH | Per-channel strike-timeout event pulse |
| out_to_o | output | NUM_CH | Per-channel lamp-out timeout event pulse |

## Verification
The hardest situation to reach is a lamp-out event: it needs a strike attempt, at least one lit clock, and then an unbroken dark run of the full window, which random lit toggling almost never produces. The bench builds it and the select-shrink case of R10 from directed sequences, with BASE_CYC reduced so every code's window fits easily, and then runs a long random phase with rare starts and long dark bursts so both event kinds also arise on both channels at once, checked every clock against a bench model.

// File: rtl/lamp_timeout_pkg.sv
package lamp_timeout_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STRIKE = 2'd1,
        PH_WATCH  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        TSEL_X1  = 2'b00,
        TSEL_X2  = 2'b01,
        TSEL_X3  = 2'b10,
        TSEL_RSV = 2'b11
    } tsel_e;

    typedef struct packed {
        logic strike;
        logic lampout;
    } evt_t;

    // Window length as a multiple of the base count; the spare code maps to the longest.
    function automatic logic [1:0] tsel_mult(input tsel_e code);
        case (code)
            TSEL_X1: return 2'd1;
            TSEL_X2: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/lamp_timeout_limit.sv
module lamp_timeout_limit
    import lamp_timeout_pkg::*;
#(
    parameter int BASE_CYC = 32768,
    parameter int CW       = $clog2(3 * BASE_CYC + 2)
) (
    input  logic [1:0]    tsel_i,
    output logic [CW-1:0] limit_o
);
    localparam logic [CW-1:0] BASE_W = CW'(BASE_CYC);

    logic [1:0] mult;

    always_comb begin
        mult = tsel_mult(tsel_e'(tsel_i));
        case (mult)
            2'd1:    limit_o = BASE_W;
            2'd2:    limit_o = BASE_W + BASE_W;
            default: limit_o = BASE_W + BASE_W + BASE_W;
        endcase
    end
endmodule

// File: rtl/lamp_timeout_chan.sv
module lamp_timeout_chan
    import lamp_timeout_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    input  logic          start_i,
    input  logic          lit_i,
    output evt_t          evt_o
);
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          held_q;
    logic [CW-1:0] cnt_nxt;
    logic          counting;
    logic          reach;

    assign cnt_nxt  = cnt_q + 1'b1;
    assign counting = tick_i && (phase_q != PH_IDLE) && !held_q;
    assign reach    = cnt_nxt >= limit_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            held_q  <= 1'b0;
            evt_o   <= '0;
        end else begin
            evt_o <= '0;
            if (start_i) begin
                phase_q <= PH_STRIKE;
                cnt_q   <= '0;
                held_q  <= 1'b0;
            end else if (lit_i) begin
                cnt_q  <= '0;
                held_q <= 1'b0;
                if (phase_q != PH_IDLE) phase_q <= PH_WATCH;
            end else if (counting) begin
                cnt_q <= cnt_nxt;
                if (reach) begin
                    held_q        <= 1'b1;
                    evt_o.strike  <= (phase_q == PH_STRIKE);
                    evt_o.lampout <= (phase_q == PH_WATCH);
                end
            end
        end
    end
endmodule

// File: rtl/lamp_timeout.sv
module lamp_timeout
    import lamp_timeout_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int BASE_CYC = 32768
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [1:0]        tsel_i,
    input  logic [NUM_CH-1:0] start_i,
    input  logic [NUM_CH-1:0] lit_i,
    output logic [NUM_CH-1:0] strike_to_o,
    output logic [NUM_CH-1:0] out_to_o
);
    localparam int CW = $clog2(3 * BASE_CYC + 2);

    logic [CW-1:0] limit;

    lamp_timeout_limit #(.BASE_CYC(BASE_CYC), .CW(CW)) limit_i (
        .tsel_i  (tsel_i),
        .limit_o (limit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        evt_t evt;
        lamp_timeout_chan #(.CW(CW)) chan_i (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .tick_i  (tick_i),
            .limit_i (limit),
            .start_i (start_i[g]),
            .lit_i   (lit_i[g]),
            .evt_o   (evt)
        );
        assign strike_to_o[g] = evt.strike;
        assign out_to_o[g]    = evt.lampout;
    end
endmodule

// File: rtl/lamp_timeout_chk.sv
module lamp_timeout_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              tick_i,
    input logic [NUM_CH-1:0] start_i,
    input logic [NUM_CH-1:0] lit_i,
    input logic [NUM_CH-1:0] strike_to_o,
    input logic [NUM_CH-1:0] out_to_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_a
        assert_excl_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            !(strike_to_o[g] && out_to_o[g]));
        assert_strike_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            strike_to_o[g] |=> !strike_to_o[g]);
        assert_out_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            out_to_o[g] |=> !out_to_o[g]);
        assert_needs_tick_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            (strike_to_o[g] || out_to_o[g]) |-> $past(tick_i));
        assert_lit_blocks_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            (strike_to_o[g] || out_to_o[g]) |-> !$past(lit_i[g]));
        assert_start_blocks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
            (strike_to_o[g] || out_to_o[g]) |-> !$past(start_i[g]));
    end
endmodule

bind lamp_timeout lamp_timeout_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .start_i     (start_i),
    .lit_i       (lit_i),
    .strike_to_o (strike_to_o),
    .out_to_o    (out_to_o)
);

// File: tb/lamp_timeout_tb_top.sv
module lamp_timeout_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 2;
    localparam int BASE = 8;

    logic           clk = 1'b0;
    logic           rst_i = 1'b1;
    logic           tick_i = 1'b0;
    logic [1:0]     tsel_i = 2'b00;
    logic [NCH-1:0] start_i = '0;
    logic [NCH-1:0] lit_i = '0;
    logic [NCH-1:0] strike_to_o, out_to_o;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state per channel: 0 idle, 1 strike, 2 watch
    int m_ph  [NCH];
    int m_cnt [NCH];
    bit m_held[NCH];
    bit e_s   [NCH];
    bit e_l   [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lamp_timeout #(.NUM_CH(NCH), .BASE_CYC(BASE)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .tsel_i(tsel_i),
        .start_i(start_i), .lit_i(lit_i),
        .strike_to_o(strike_to_o), .out_to_o(out_to_o)
    );

    function automatic int window(input logic [1:0] code);
        case (code)
            2'b00:   return BASE;
            2'b01:   return 2 * BASE;
            default: return 3 * BASE;
        endcase
    endfunction

    task automatic model_update(input bit rst, input bit tk, input logic [1:0] sel,
                                input logic [NCH-1:0] st, input logic [NCH-1:0] lt);
        for (int c = 0; c < NCH; c++) begin
            e_s[c] = 1'b0;
            e_l[c] = 1'b0;
            if (rst) begin
                m_ph[c] = 0; m_cnt[c] = 0; m_held[c] = 1'b0;
            end else if (st[c]) begin
                m_ph[c] = 1; m_cnt[c] = 0; m_held[c] = 1'b0;
            end else if (lt[c]) begin
                m_cnt[c] = 0; m_held[c] = 1'b0;
                if (m_ph[c] != 0) m_ph[c] = 2;
            end else if (tk && m_ph[c] != 0 && !m_held[c]) begin
                m_cnt[c]++;
                if (m_cnt[c] >= window(sel)) begin
                    m_held[c] = 1'b1;
                    if (m_ph[c] == 1) e_s[c] = 1'b1; else e_l[c] = 1'b1;
                end
            end
        end
    endtask

    task automatic step(input string tag, input bit rst, input bit tk, input logic [1:0] sel,
                        input logic [NCH-1:0] st, input logic [NCH-1:0] lt);
        @(negedge clk);
        rst_i = rst; tick_i = tk; tsel_i = sel; start_i = st; lit_i = lt;
        model_update(rst, tk, sel, st, lt);
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) begin
            n_cmp++;
            if (strike_to_o[c] !== e_s[c] || out_to_o[c] !== e_l[c]) begin
                n_bad++;
                $display("FAIL %s ch%0d: actual strike=%b out=%b expected strike=%b out=%b",
                         tag, c, strike_to_o[c], out_to_o[c], e_s[c], e_l[c]);
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd1234);

        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1 reset", 1, 1, 2'b00, '0, '0);

        // R12: idle channels never count
        for (int i = 0; i < 4 * BASE; i++) step("R12 idle", 0, 1, 2'b00, '0, NCH'(i % 3 == 0));

        // R2 / R3 / R4 / R8: strike timeout for every select code, then hold
        for (int code = 0; code < 4; code++) begin
            step("R4 start", 0, 0, 2'(code), 2'b01, '0);
            for (int i = 0; i < 3 * BASE + 6; i++)
                step(code == 3 ? "R3 R4 R8 window" : "R2 R4 R8 window", 0, 1, 2'(code), '0, '0);
        end

        // R5: lit then dark -> lamp-out event on ch1
        step("R5 start", 0, 0, 2'b00, 2'b10, '0);
        for (int i = 0; i < 3; i++) step("R5 lit", 0, 1, 2'b00, '0, 2'b10);
        for (int i = 0; i < BASE + 4; i++) step("R5 lampout", 0, 1, 2'b00, '0, '0);

        // R6: lit pulse just before window restarts count
        step("R6 start", 0, 0, 2'b00, 2'b01, '0);
        for (int i = 0; i < BASE - 1; i++) step("R6 dark", 0, 1, 2'b00, '0, '0);
        step("R6 lit", 0, 1, 2'b00, '0, 2'b01);
        for (int i = 0; i < BASE + 3; i++) step("R6 recount", 0, 1, 2'b00, '0, '0);

        // R9: ticks sparse
        step("R9 start", 0, 0, 2'b00, 2'b11, '0);
        for (int i = 0; i < 4 * BASE; i++) step("R9 sparse", 0, (i % 3 == 0), 2'b00, '0, '0);

        // R10: shrink window below current count
        step("R10 start", 0, 0, 2'b10, 2'b01, '0);
        for (int i = 0; i < 2 * BASE; i++) step("R10 count", 0, 1, 2'b10, '0, '0);
        step("R10 shrink notick", 0, 0, 2'b00, '0, '0);
        step("R10 shrink tick", 0, 1, 2'b00, '0, '0);
        step("R10 after", 0, 1, 2'b00, '0, '0);

        // R7: restart from lamp-out watch into strike mode
        step("R7 start", 0, 0, 2'b00, 2'b01, '0);
        step("R7 lit", 0, 1, 2'b00, '0, 2'b01);
        for (int i = 0; i < BASE / 2; i++) step("R7 dark", 0, 1, 2'b00, '0, '0);
        step("R7 restart", 0, 1, 2'b00, 2'b01, '0);
        for (int i = 0; i < BASE + 3; i++) step("R7 strike", 0, 1, 2'b00, '0, '0);

        // R11: random mix, independent channels under one select
        for (int i = 0; i < 30000; i++) begin
            logic [NCH-1:0] st, lt;
            logic [1:0] sel;
            for (int c = 0; c < NCH; c++) begin
                st[c] = ($urandom % 100) < 2;
                lt[c] = ($urandom % 100) < ((i / 500) % 2 == 0 ? 3 : 40);
            end
            sel = 2'((i / 700) % 4);
            step("R11 random", 0, ($urandom % 4) != 0, sel, st, lt);
        end

        finish_run();
    end
endmodule